// File: doc/BRIEF.md
# PS/2 Mailbox Event Interrupt Unit

This unit sits between the host-facing keyboard-controller logic and an embedded microcontroller. It watches the mailbox traffic of the keyboard and mouse channels: host reads of keyboard or mouse data, host command writes to either device, and bytes arriving from either device. It also watches every change of the 8-bit controller status byte. Each event is latched in a sticky status bit that the microcontroller clears by writing 1. Every status bit has its own enable, and the enabled bits are merged into one registered, level-sensitive interrupt line.

The microcontroller reaches four registers through a plain register port. Writes take effect at the clock edge, and read data follows the address with no added delay. The registers are the event status, the event enable, a read-only mirror of the controller status byte, and a clock-disable control register. The control register also selects who drives the PS/2 clock-disable of each channel: the host's own disable request, or a disable bit that the microcontroller owns. All event inputs are one-cycle pulses or plain levels; there is no streaming data path, so no valid/ready handshake applies.

Top module: `ps2_evt_irq_unit`

## Requirements
- R1: After reset the status and enable registers read 0, `irq` is 0, and a status input held at the reset value `STAT_RST` (default 8'h10) records no change event.
- R2: A pulse on `host_kb_rd` sets status bit 4, and a pulse on `host_ms_rd` sets status bit 5. Each is visible on a read in the cycle after the pulse.
- R3: A pulse on `host_kb_wr` sets status bit 2, and a pulse on `host_ms_wr` sets status bit 3.
- R4: A pulse on `dev_kb_rx` sets status bit 0, and a pulse on `dev_ms_rx` sets status bit 1.
- R5: Status bit 7 sets in the cycle after `host_stat` takes a value different from its value in the previous cycle. A `host_stat` that holds its value sets nothing.
- R6: Status bits are sticky. Writing 1 at address 0 clears that bit, and writing 0 leaves it unchanged.
- R7: When a set event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The enable register at address 1 uses the same bit layout as the status register. Bit 6 of both registers always reads 0.
- R9: `irq` is registered. It equals the OR over all bits of status AND enable from the previous cycle, so it rises one cycle after an enabled bit sets and falls one cycle after the last enabled bit clears.
- R10: A read at address 2 returns the current `host_stat`.
- R11: Control register (address 3) bit 2 selects the clock-disable source. When it is 1, `kb_clkdis` and `ms_clkdis` follow control bits 0 and 1. When it is 0, they follow `host_kb_clkdis` and `host_ms_clkdis`.
- R12: Control register bits 4 and 5 read back `host_kb_clkdis` and `host_ms_clkdis`, and bits 7, 6 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stat | input | 8 | Controller status byte as the host sees it |
| host_kb_rd | input | 1 | Pulse: host read keyboard data |
| host_ms_rd | input | 1 | Pulse: host read mouse data |
| host_kb_wr | input | 1 | Pulse: host wrote a keyboard command byte |
| host_ms_wr | input | 1 | Pulse: host wrote a mouse command byte |
| dev_kb_rx | input | 1 | Pulse: byte received from the keyboard |
| dev_ms_rx | input | 1 | Pulse: byte received from the mouse |
| host_kb_clkdis | input | 1 | Host request to disable the keyboard clock |
| host_ms_clkdis | input | 1 | Host request to disable the mouse clock |
| mc_addr | input | 2 | Microcontroller register address |
| mc_we | input | 1 | Microcontroller write strobe |
| mc_wdata | input | 8 | Microcontroller write data |
| mc_rdata | output | 8 | Read data for `mc_addr` |
| kb_clkdis | output | 1 | Keyboard clock-disable output |
| ms_clkdis | output | 1 | Mouse clock-disable output |
| irq | output | 1 | Level interrupt to the microcontroller |

## Verification
The assertions take for granted that event inputs are clean synchronous signals, meaning any high cycle counts as one event. They also assume that `host_stat` is already synchronous, so each cycle-to-cycle difference is a real change. The bench drives every input at the falling edge, raises event inputs for exactly one cycle, and changes `host_stat` only between vectors. It holds `host_stat` at `STAT_RST` through reset. This keeps the stimulus within those assumptions and keeps every expected status value exact.

// File: rtl/ps2_evt_pkg.sv
package ps2_evt_pkg;
  localparam int EVT_W = 8;

  // status / enable bit positions
  localparam int B_KB_RX  = 0;
  localparam int B_MS_RX  = 1;
  localparam int B_KB_WR  = 2;
  localparam int B_MS_WR  = 3;
  localparam int B_KB_RD  = 4;
  localparam int B_MS_RD  = 5;
  localparam int B_RSVD   = 6;
  localparam int B_CHG    = 7;

  localparam logic [EVT_W-1:0] LIVE_MASK = ~(EVT_W'(1) << B_RSVD);

  // clock-disable control register layout
  localparam int C_MC_KB  = 0;
  localparam int C_MC_MS  = 1;
  localparam int C_SEL    = 2;
  localparam int C_HST_KB = 4;
  localparam int C_HST_MS = 5;

  typedef enum logic [1:0] {
    RA_STS = 2'd0,
    RA_EN  = 2'd1,
    RA_MIR = 2'd2,
    RA_CLK = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ps2_evt_sticky_bank.sv
module ps2_evt_sticky_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;   // set beats clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign sts_o[i] = q;

      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i[i]) |=> q);
      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !q);
      a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q);
    end else begin : g_dead
      assign sts_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ps2_stat_chg_det.sv
module ps2_stat_chg_det #(
  parameter int DW = 8,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] stat_i,
  output logic          chg_o
);
  logic [DW-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stat_i;
  end

  assign chg_o = rst_n && (stat_i != prev_q);

  // R5: a value that held for a whole cycle after reset never flags a change
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(stat_i)) |-> !chg_o);
  // R5: a fresh value after a settled cycle always flags a change
  a_r5_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(stat_i)) |-> chg_o);
endmodule

// File: rtl/ps2_clkdis_sel.sv
module ps2_clkdis_sel #(
  parameter int NCH = 2
) (
  input  logic           sel_mc_i,
  input  logic [NCH-1:0] host_dis_i,
  input  logic [NCH-1:0] mc_dis_i,
  output logic [NCH-1:0] dis_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign dis_o[c] = sel_mc_i ? mc_dis_i[c] : host_dis_i[c];
  end
endmodule

// File: rtl/ps2_evt_irq_unit.sv
module ps2_evt_irq_unit
  import ps2_evt_pkg::*;
#(
  parameter logic [7:0] STAT_RST = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_stat,
  input  logic       host_kb_rd,
  input  logic       host_ms_rd,
  input  logic       host_kb_wr,
  input  logic       host_ms_wr,
  input  logic       dev_kb_rx,
  input  logic       dev_ms_rx,
  input  logic       host_kb_clkdis,
  input  logic       host_ms_clkdis,
  input  logic [1:0] mc_addr,
  input  logic       mc_we,
  input  logic [7:0] mc_wdata,
  output logic [7:0] mc_rdata,
  output logic       kb_clkdis,
  output logic       ms_clkdis,
  output logic       irq
);
  localparam int NCH = 2;

  logic             chg;
  logic [EVT_W-1:0] set_v, clr_v, sts, en_q;
  logic [2:0]       ctl_q;
  logic             irq_q;
  logic [NCH-1:0]   dis_v;

  ps2_stat_chg_det #(.DW(8), .RST_VAL(STAT_RST)) u_chg (
    .clk(clk), .rst_n(rst_n), .stat_i(host_stat), .chg_o(chg)
  );

  always_comb begin
    set_v          = '0;
    set_v[B_KB_RX] = dev_kb_rx;
    set_v[B_MS_RX] = dev_ms_rx;
    set_v[B_KB_WR] = host_kb_wr;
    set_v[B_MS_WR] = host_ms_wr;
    set_v[B_KB_RD] = host_kb_rd;
    set_v[B_MS_RD] = host_ms_rd;
    set_v[B_CHG]   = chg;
  end

  assign clr_v = (mc_we && mc_addr == RA_STS) ? mc_wdata : '0;

  ps2_evt_sticky_bank #(.W(EVT_W), .LIVE(LIVE_MASK)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .sts_o(sts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (mc_we && mc_addr == RA_EN)  en_q  <= mc_wdata & LIVE_MASK;
      if (mc_we && mc_addr == RA_CLK) ctl_q <= mc_wdata[2:0];
      irq_q <= |(sts & en_q);
    end
  end
  assign irq = irq_q;

  ps2_clkdis_sel #(.NCH(NCH)) u_dis (
    .sel_mc_i  (ctl_q[C_SEL]),
    .host_dis_i({host_ms_clkdis, host_kb_clkdis}),
    .mc_dis_i  ({ctl_q[C_MC_MS], ctl_q[C_MC_KB]}),
    .dis_o     (dis_v)
  );
  assign kb_clkdis = dis_v[0];
  assign ms_clkdis = dis_v[1];

  always_comb begin
    mc_rdata = '0;
    unique case (mc_addr)
      RA_STS: mc_rdata = sts;
      RA_EN:  mc_rdata = en_q;
      RA_MIR: mc_rdata = host_stat;
      RA_CLK: begin
        mc_rdata[2:0]    = ctl_q;
        mc_rdata[C_HST_KB] = host_kb_clkdis;
        mc_rdata[C_HST_MS] = host_ms_clkdis;
      end
      default: mc_rdata = '0;
    endcase
  end

  // R9: interrupt tracks enabled status one cycle later
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts & en_q)) |=> irq);
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts & en_q)) |=> !irq);
  // R8: reserved position never holds state
  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sts[B_RSVD] && !en_q[B_RSVD]);
endmodule

// File: tb/tb_ps2_evt_irq_unit.sv
module tb_ps2_evt_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_stat = 8'h10;
  logic       host_kb_rd = 0, host_ms_rd = 0, host_kb_wr = 0, host_ms_wr = 0;
  logic       dev_kb_rx = 0, dev_ms_rx = 0;
  logic       host_kb_clkdis = 0, host_ms_clkdis = 0;
  logic [1:0] mc_addr = 2'd0;
  logic       mc_we = 0;
  logic [7:0] mc_wdata = 8'h00;
  logic [7:0] mc_rdata;
  logic       kb_clkdis, ms_clkdis, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ps2_evt_irq_unit dut (.*);

  // vector: {ev[5:0] = ms_rd,kb_rd,ms_wr,kb_wr,ms_rx,kb_rx ; host_stat ; expected status}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {6'b000001, 8'h10, 8'h01},  // R4 kb rx
    {6'b000010, 8'h10, 8'h02},  // R4 ms rx
    {6'b000100, 8'h10, 8'h04},  // R3 kb wr
    {6'b001000, 8'h10, 8'h08},  // R3 ms wr
    {6'b010000, 8'h10, 8'h10},  // R2 kb rd
    {6'b100000, 8'h10, 8'h20},  // R2 ms rd
    {6'b000000, 8'h5A, 8'h80},  // R5 change
    {6'b000000, 8'h5A, 8'h00},  // R5 stable
    {6'b111111, 8'h5A, 8'h3F},  // R2 R3 R4 all
    {6'b011000, 8'hA5, 8'h98}   // R5 with R2 R3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    mc_addr = a;
    #1 d = mc_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    mc_addr = a; mc_wdata = d; mc_we = 1;
    @(negedge clk);
    mc_we = 0; mc_wdata = 8'h00;
  endtask

  task automatic set_ev(input logic [5:0] ev);
    {host_ms_rd, host_kb_rd, host_ms_wr, host_kb_wr, dev_ms_rx, dev_kb_rx} = ev;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 8'h00);
    rd(2'd1, d); check("R1 enable", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd2, d); check("R10 mirror", d, 8'h10);

    // table walk
    for (int v = 0; v < NV; v++) begin
      set_ev(VEC[v][21:16]);
      host_stat = VEC[v][15:8];
      @(negedge clk);
      set_ev(6'd0);
      rd(2'd0, d); check($sformatf("R2-5 vector %0d", v), d, VEC[v][7:0]);
      wr(2'd0, 8'hFF);
      rd(2'd0, d); check($sformatf("R6 clear vec %0d", v), d, 8'h00);
    end

    // R6 write 0 has no effect, partial clear
    set_ev(6'b110000); @(negedge clk); set_ev(6'd0);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R6 write0", d, 8'h30);
    wr(2'd0, 8'h10);
    rd(2'd0, d); check("R6 partial clear", d, 8'h20);
    wr(2'd0, 8'hFF);

    // R7 set wins over simultaneous clear
    set_ev(6'b010000); mc_addr = 2'd0; mc_wdata = 8'h10; mc_we = 1;
    @(negedge clk);
    set_ev(6'd0); mc_we = 0;
    rd(2'd0, d); check("R7 set wins", d, 8'h10);
    wr(2'd0, 8'hFF);

    // R8 enable layout and reserved bit
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R8 enable reserved", d, 8'hBF);
    wr(2'd1, 8'h01);
    rd(2'd1, d); check("R8 enable readback", d, 8'h01);

    // R9 irq timing
    set_ev(6'b000010); @(negedge clk); set_ev(6'd0);
    @(negedge clk);
    check("R9 disabled bit no irq", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hFF);
    set_ev(6'b000001); @(negedge clk); set_ev(6'd0);
    check("R9 irq not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R9 irq high", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h01);
    check("R9 irq one more cycle", {7'd0, irq}, 8'h01);
    @(negedge clk);
    check("R9 irq low", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h00);

    // R10 mirror tracks
    host_stat = 8'hC3; @(negedge clk);
    rd(2'd2, d); check("R10 mirror", d, 8'hC3);
    wr(2'd0, 8'hFF);

    // R11 / R12 clock disable
    host_kb_clkdis = 1; host_ms_clkdis = 0; #1;
    check("R11 host kb", {6'd0, ms_clkdis, kb_clkdis}, 8'h01);
    rd(2'd3, d); check("R12 host bits", d, 8'h10);
    wr(2'd3, 8'h06);
    #1 check("R11 mc select", {6'd0, ms_clkdis, kb_clkdis}, 8'h02);
    host_ms_clkdis = 1;
    rd(2'd3, d); check("R12 readback", d, 8'h36);
    wr(2'd3, 8'h03);
    #1 check("R11 host select", {6'd0, ms_clkdis, kb_clkdis}, 8'h03);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule